// File: doc/BRIEF.md
# Code Register Byte Emitter

This block is the final stage of a pipelined binary arithmetic coder. Upstream logic has already decided, for each coded decision, whether the interval base must move (a hit), by how much (the addend) and how many bits of renormalisation follow (the shift). This stage owns the code register. It applies each update, tracks how many shifted bits remain before the next byte boundary, and turns the bits that leave the top of the register into the compressed byte stream. The stream goes through a small output queue.

Each byte is held back for one boundary as a pending byte, so that a later carry out of the register can still increment it. After any 0xFF byte the next byte carries only seven bits, so no marker-like pair can appear. An end-of-block flush command closes the stream and returns the stage to its starting state for the next block. Both streams use valid/ready handshakes. An update is taken on a cycle where `in_valid` and `in_ready` are both high. A byte leaves on a cycle where `out_valid` and `out_ready` are both high. The producer must hold an update's fields steady until it is taken. `out_ready` may be dropped at any time. `in_ready` falls while an update still has shift bits left, and also whenever the output queue is full.

Top module: `code_byte_emitter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The code register is zero, the boundary counter holds 12 and no byte is pending.
- R2: On an update with `in_hit` set, `in_addend` is added to the code register before that update's shift is applied. With `in_hit` clear the register only shifts.
- R3: A byte boundary occurs when the boundary counter reaches zero. The counter starts at 12. It reloads with 8 after a boundary and with 7 when the byte output at that boundary is 0xFF. The byte formed at the first boundary of a block is a placeholder and is never output.
- R4: If bit 27 (the carry) of the shifted register is set at a boundary and the pending byte is not 0xFF, the pending byte is incremented before it is output. If the increment gives 0xFF, the carry bit is cleared and the next byte is taken from bits 26..20 only.
- R5: Each cycle shifts by at most the bits left before the next boundary. An update whose shift fits within the current counter completes in its acceptance cycle, so `in_ready` is high again in the next cycle. A longer update holds `in_ready` low until its remaining bits are consumed.
- R6: No byte is lost or repeated under back-pressure. `out_data` holds steady while `out_valid` is high and `out_ready` is low. Nothing is written to a full output queue.
- R7: An update with `in_flush` set uses `in_addend` as the interval width. The low 16 register bits are set to ones, and 0x8000 is subtracted if the result reaches base plus width. Two byte boundaries follow. The final pending byte is then output unless it is 0xFF, and the state returns to its reset values.
- R8: For any update stream, the output byte sequence equals that of a sequential bit-at-a-time model of R2 to R7. The register is 28 bits including the carry, and sums wrap modulo 2^28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Update offered |
| in_ready | output | 1 | Update can be taken this cycle |
| in_hit | input | 1 | Add the addend to the code register |
| in_shift | input | 4 | Renormalisation shift, 0 to 15 |
| in_addend | input | 16 | Addend, or interval width on a flush |
| in_flush | input | 1 | Update is the end-of-block flush |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Compressed byte |

## Verification
The assertions assume that an offered update keeps its fields unchanged until it is accepted. They also assume the consumer may hold off `out_ready` for any number of cycles. The bench keeps to the first rule by driving each update once and holding it until the handshake. It tests the second with random ready rates, from sparse to always ready. Random addends are allowed to overflow the register. Wrapping behaviour is defined by R8 and reproduced by the bench model, so a stream that a real coder would never produce still has one expected result. Hand-computed streams pin down the first-boundary placeholder, a carry into the pending byte, and flushes that end with a kept byte and with a dropped 0xFF.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
  localparam int CODE_W   = 27;
  localparam int REG_W    = CODE_W + 1;
  localparam int CT_W     = 4;
  localparam int CT_START = 12;
  localparam int CT_NORM  = 8;
  localparam int CT_STUFF = 7;

  localparam logic [REG_W-1:0] KEEP_NORM  = {{(REG_W-CT_NORM-1){1'b0}} , {(CT_NORM+1){1'b0}}} | ((REG_W)'(1) << (REG_W-CT_NORM-1)) - (REG_W)'(1);
  localparam logic [REG_W-1:0] KEEP_STUFF = ((REG_W)'(1) << (REG_W-CT_NORM)) - (REG_W)'(1);

  typedef enum logic [1:0] {PH_IDLE, PH_SHIFT, PH_FL2, PH_FLEND} phase_t;

  typedef struct packed {
    logic [REG_W-1:0] c;
    logic [7:0]       b;
    logic [CT_W-1:0]  ct;
    logic [7:0]       commit;
  } bnd_t;

  function automatic bnd_t byte_boundary(input logic [REG_W-1:0] c, input logic [7:0] b);
    bnd_t r;
    logic [7:0] binc;
    binc     = b + 8'd1;
    r.commit = b;
    r.b      = c[REG_W-2 -: 8];
    r.c      = c & KEEP_NORM;
    r.ct     = CT_W'(CT_NORM);
    if (b == 8'hFF) begin
      r.b  = c[REG_W-1 -: 8];
      r.c  = c & KEEP_STUFF;
      r.ct = CT_W'(CT_STUFF);
    end else if (c[REG_W-1]) begin
      r.commit = binc;
      if (binc == 8'hFF) begin
        r.b  = {1'b0, c[REG_W-2 -: 7]};
        r.c  = c & KEEP_STUFF;
        r.ct = CT_W'(CT_STUFF);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/cbe_fifo.sv
module cbe_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pop;

  assign pop   = valid && ready;
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign valid = (cnt != '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: the producer never writes into a full queue
  p_push_has_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6: a byte offered and not taken stays put
  p_hold_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/cbe_core.sv
module cbe_core
  import cbe_pkg::*;
#(
  parameter int SHIFT_W = 4,
  parameter int ADD_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_hit,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [ADD_W-1:0]   in_addend,
  input  logic               in_flush,
  input  logic               q_full,
  output logic               q_push,
  output logic [7:0]         q_data
);
  localparam int REM_W = (SHIFT_W > CT_W) ? SHIFT_W : CT_W;
  localparam int XW    = REG_W + 1;
  localparam logic [REG_W-1:0] LOW_ONES = ((REG_W)'(1) << ADD_W) - (REG_W)'(1);
  localparam logic [XW-1:0]    HALF     = (XW)'(1) << (ADD_W - 1);

  phase_t           phase;
  logic [REG_W-1:0] c_q, c_src, c_sh, c_fl;
  logic [XW-1:0]    top_x, c_or;
  logic [CT_W-1:0]  ct_q, ct_dec;
  logic [7:0]       b_q;
  logic             started_q;
  logic [REM_W-1:0] rem_q, rem_src, k, rem_left;
  logic             accept, active, bo;
  bnd_t             bres;

  assign in_ready = (phase == PH_IDLE) && !q_full;
  assign accept   = in_valid && in_ready;

  // flush: pick the value inside the interval with most trailing ones
  always_comb begin
    top_x = {1'b0, c_q} + XW'(in_addend);
    c_or  = {1'b0, c_q | LOW_ONES};
    if (c_or >= top_x) c_or = c_or - HALF;
    c_fl  = c_or[REG_W-1:0];
  end

  always_comb begin
    c_src   = c_q;
    rem_src = rem_q;
    active  = 1'b0;
    case (phase)
      PH_IDLE: begin
        c_src   = in_flush ? c_fl : c_q + (in_hit ? REG_W'(in_addend) : '0);
        rem_src = in_flush ? REM_W'(ct_q) : REM_W'(in_shift);
        active  = accept;
      end
      PH_SHIFT: active = !q_full;
      PH_FL2: begin
        rem_src = REM_W'(ct_q);
        active  = !q_full;
      end
      default: rem_src = '0;
    endcase
    k        = (rem_src < REM_W'(ct_q)) ? rem_src : REM_W'(ct_q);
    c_sh     = c_src << k;
    ct_dec   = ct_q - CT_W'(k);
    rem_left = rem_src - k;
    bo       = active && (ct_dec == '0);
    bres     = byte_boundary(c_sh, b_q);
    if (phase == PH_FLEND) begin
      q_push = !q_full && (b_q != 8'hFF);
      q_data = b_q;
    end else begin
      q_push = bo && started_q;
      q_data = bres.commit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      c_q       <= '0;
      ct_q      <= CT_W'(CT_START);
      b_q       <= '0;
      started_q <= 1'b0;
      rem_q     <= '0;
    end else begin
      if (active) begin
        rem_q <= rem_left;
        if (bo) begin
          c_q       <= bres.c;
          ct_q      <= bres.ct;
          b_q       <= bres.b;
          started_q <= 1'b1;
        end else begin
          c_q  <= c_sh;
          ct_q <= ct_dec;
        end
      end
      case (phase)
        PH_IDLE:
          if (accept) begin
            if (in_flush)           phase <= PH_FL2;
            else if (rem_left != 0) phase <= PH_SHIFT;
          end
        PH_SHIFT: if (active && rem_left == 0) phase <= PH_IDLE;
        PH_FL2:   if (active) phase <= PH_FLEND;
        default:
          if (!q_full) begin
            phase     <= PH_IDLE;
            c_q       <= '0;
            ct_q      <= CT_W'(CT_START);
            b_q       <= '0;
            started_q <= 1'b0;
          end
      endcase
    end
  end

  // R5: a shift longer than the bits left to the boundary blocks the next update
  p_long_shift_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_flush && (REM_W'(in_shift) > REM_W'(ct_q))) |=> !in_ready);

  // R3: the counter reloads with 7 or 8 after a boundary
  p_reload_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bo |=> (ct_q == CT_W'(CT_NORM) || ct_q == CT_W'(CT_STUFF)));

  // R3: between updates the counter lies in 1..12
  p_counter_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (ct_q != '0 && ct_q <= CT_W'(CT_START)));

  // R4: a written 0xFF leaves only seven bits for the next byte
  p_stuff_after_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && q_data == 8'hFF && phase != PH_FLEND) |=> (ct_q == CT_W'(CT_STUFF)));
endmodule

// File: rtl/code_byte_emitter.sv
module code_byte_emitter #(
  parameter int SHIFT_W    = 4,
  parameter int ADD_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_hit,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [ADD_W-1:0]   in_addend,
  input  logic               in_flush,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data
);
  logic       q_full, q_push;
  logic [7:0] q_data;

  cbe_core #(.SHIFT_W(SHIFT_W), .ADD_W(ADD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_hit    (in_hit),
    .in_shift  (in_shift),
    .in_addend (in_addend),
    .in_flush  (in_flush),
    .q_full    (q_full),
    .q_push    (q_push),
    .q_data    (q_data)
  );

  cbe_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (q_data),
    .full  (q_full),
    .valid (out_valid),
    .ready (out_ready),
    .dout  (out_data)
  );
endmodule

// File: tb/code_byte_emitter_test.sv
module code_byte_emitter_test;
  localparam int MASK = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, in_hit = 1'b0, in_flush = 1'b0;
  logic [3:0]  in_shift = '0;
  logic [15:0] in_addend = '0;
  logic        out_valid, out_ready;
  logic [7:0]  out_data;

  int checks = 0, errors = 0, cycles = 0, rdy_pct = 100;
  logic [7:0] expq[$];
  string      tagq[$];
  string      cur_tag = "R8";

  int unsigned mc = 0, mct = 12, mb = 0;
  bit mstarted = 0;

  code_byte_emitter uut (.*);

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // reference model, one bit at a time
  function automatic void m_commit(int unsigned v);
    if (mstarted) begin
      expq.push_back(v[7:0]);
      tagq.push_back(cur_tag);
    end
    mstarted = 1;
  endfunction

  function automatic void m_boundary();
    if (mb == 255) begin
      m_commit(mb); mb = mc >> 20; mc &= 32'hFFFFF; mct = 7;
    end else if (mc < 32'h800_0000) begin
      m_commit(mb); mb = mc >> 19; mc &= 32'h7FFFF; mct = 8;
    end else begin
      mb = mb + 1;
      if (mb == 255) begin
        mc &= 32'h7FF_FFFF;
        m_commit(mb); mb = mc >> 20; mc &= 32'hFFFFF; mct = 7;
      end else begin
        m_commit(mb); mb = mc >> 19; mc &= 32'h7FFFF; mct = 8;
      end
    end
  endfunction

  function automatic void m_update(bit hit, int unsigned sh, int unsigned add);
    if (hit) mc = (mc + add) & MASK;
    for (int i = 0; i < sh; i++) begin
      mc = (mc << 1) & MASK;
      mct--;
      if (mct == 0) m_boundary();
    end
  endfunction

  function automatic void m_flush(int unsigned a);
    int unsigned top;
    top = mc + a;
    mc = mc | 32'hFFFF;
    if (mc >= top) mc -= 32'h8000;
    mc = (mc << mct) & MASK; m_boundary();
    mc = (mc << mct) & MASK; m_boundary();
    if (mb != 255) m_commit(mb);
    mc = 0; mct = 12; mb = 0; mstarted = 0;
  endfunction

  task automatic send(bit hit, int sh, int add, bit fl, bit use_model);
    @(negedge clk);
    in_valid = 1; in_hit = hit; in_shift = sh[3:0]; in_addend = add[15:0]; in_flush = fl;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (use_model) begin
      if (fl) m_flush(add); else m_update(hit, sh, add);
    end
    #1 in_valid = 0;
  endtask

  task automatic expect_byte(logic [7:0] v, string tag);
    expq.push_back(v);
    tagq.push_back(tag);
  endtask

  // consumer: random ready, compare every transfer
  initial begin
    out_ready = 0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(99) < rdy_pct);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) check(0, "R6", "unexpected byte", out_data, 0);
        else begin
          string t;
          logic [7:0] e;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(out_data == e, t, "byte", out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    // R3 and R7: 12 bits to first boundary, trailing 0xFF dropped
    send(1, 12, 1, 0, 0);
    send(0, 8, 0, 0, 0);
    expect_byte(8'h00, "R3");
    expect_byte(8'h02, "R2");
    send(0, 0, 16'h8000, 1, 0);
    expect_byte(8'h0F, "R7");

    // R7: empty block flush
    send(0, 0, 16'h8000, 1, 0);
    expect_byte(8'hFF, "R7");
    expect_byte(8'h7F, "R7");

    // R4: carry into pending byte 0xE0
    send(1, 12, 16'h7000, 0, 0);
    for (int i = 0; i < 9; i++) send(1, 0, 16'hFFFF, 0, 0);
    send(0, 8, 0, 0, 0);
    expect_byte(8'hE1, "R4");
    send(0, 0, 16'h8000, 1, 0);
    expect_byte(8'h1F, "R7");
    expect_byte(8'hFF, "R7");
    expect_byte(8'h7F, "R7");

    // R5: stall timing, queue empty so ready only depends on phase
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    cur_tag = "R5";
    send(0, 15, 0, 0, 1);
    @(negedge clk); #2;
    check(in_ready == 0, "R5", "in_ready during long shift", in_ready, 0);
    @(negedge clk); #2;
    check(in_ready == 1, "R5", "in_ready after long shift", in_ready, 1);
    send(1, 3, 16'h1234, 0, 1);
    @(negedge clk); #2;
    check(in_ready == 1, "R5", "in_ready after short shift", in_ready, 1);
    send(1, 9, 16'h00FF, 0, 1);
    send(0, 0, 16'hC000, 1, 1);

    // R8 and R6: random blocks under varying back-pressure
    for (int blk = 0; blk < 8; blk++) begin
      int n;
      rdy_pct = (blk % 4 == 0) ? 100 : 20 + 20 * (blk % 4);
      cur_tag = (blk % 2 == 0) ? "R8" : "R6";
      n = 40 + $urandom_range(160);
      for (int u = 0; u < n; u++) begin
        int mode;
        mode = $urandom_range(9);
        if (mode < 3) send(1, $urandom_range(2), 16'hF000 | $urandom_range(16'h0FFF), 0, 1);
        else send($urandom_range(1), $urandom_range(15), $urandom_range(16'hFFFF), 0, 1);
      end
      send(0, 0, 16'h8000 | $urandom_range(16'h7FFF), 1, 1);
    end

    rdy_pct = 100;
    for (int w = 0; w < 2000 && expq.size() != 0; w++) @(negedge clk);
    check(expq.size() == 0, "R8", "bytes still expected", expq.size(), 0);
    repeat (10) @(negedge clk);
    check(out_valid == 0, "R6", "extra byte at end", out_valid, 0);
    finish_run();
  end
endmodule